// File: doc/BRIEF.md
# SPI Graphics Command Deserializer

This block receives a byte stream from a host over an SPI link (mode 0, eight bits per word, most significant bit first) and turns it into complete drawing commands for a 2D engine. Each command opens with a one-byte opcode that fixes how many payload bytes follow. Sixteen-bit coordinates arrive high byte first. Once a command's last byte is in, the block writes one decoded entry into a small command queue. The drawing engine pops entries from that queue at its own rate.

SCK, chip select and MOSI are asynchronous to the system clock. Each passes through a two-flop synchroniser, and a data bit is taken on the detected rising edge of SCK. When chip select goes high, any partial byte and any partial command are thrown away. Commands whose opcode is not known are dropped, and so are commands that complete while the queue is full. Each of these two cases sets its own sticky flag, which only reset clears.

Top module: `gfx_cmd_deser`

## Requirements
- R1: After reset, cmd_valid, err_opcode and err_overflow are all 0.
- R2: While spi_cs_n is low, the block takes spi_mosi on each rising edge of spi_sck. Eight bits make one byte, first bit most significant.
- R3: Opcode 0x01 (line) is followed by 10 bytes. It yields one entry with cmd_xa = b0:b1, cmd_ya = b2:b3, cmd_xb = b4:b5, cmd_yb = b6:b7 (first byte of each pair in bits 15:8), cmd_color = b8 and cmd_option = b9.
- R4: Opcode 0x02 (clip) is followed by 8 bytes. These map to the four coordinates as in R3. cmd_color and cmd_option are 0.
- R5: Opcode 0x03 (clear) is followed by 1 byte, which appears on cmd_color. The coordinates and cmd_option are 0.
- R6: Opcode 0x04 (swap) has no payload. It yields an entry as soon as the opcode byte is complete, with every field except cmd_opcode at 0.
- R7: Raising spi_cs_n before a command or a byte is complete discards the partial data, and no entry is produced. The first full byte after spi_cs_n falls again is read as an opcode.
- R8: Opcodes 0x00 and 0x05 to 0xFF are dropped without an entry and set err_opcode, which stays 1 until reset. The next byte is read as an opcode.
- R9: The queue holds DEPTH (default 8) entries in arrival order. cmd_valid is 1 while the queue is not empty. The head entry is removed on a clock edge where cmd_valid and cmd_ready are both 1.
- R10: A command that completes while the queue holds DEPTH entries is dropped and the queue contents stay the same. err_overflow is set and stays 1 until reset. It stays 0 while no command has been dropped.
- R11: Several commands sent back to back inside one chip-select frame are each decoded, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, asynchronous |
| spi_cs_n | input | 1 | SPI chip select, active low, asynchronous |
| spi_mosi | input | 1 | SPI data from host |
| cmd_ready | input | 1 | Engine takes the head entry |
| cmd_valid | output | 1 | Queue holds at least one entry |
| cmd_opcode | output | 8 | Opcode of head entry |
| cmd_xa | output | 16 | First X coordinate |
| cmd_ya | output | 16 | First Y coordinate |
| cmd_xb | output | 16 | Second X coordinate |
| cmd_yb | output | 16 | Second Y coordinate |
| cmd_color | output | 8 | Colour index |
| cmd_option | output | 8 | Option byte |
| err_opcode | output | 1 | Sticky unknown-opcode flag |
| err_overflow | output | 1 | Sticky dropped-command flag |

## Verification
A bit counter that slips by one shows up in the next entry as byte-swapped or shifted coordinates, or as a missing entry. This is visible a few system cycles after the last SCK edge of that command. A payload index or parser state left stale after an abort makes the following command decode with a wrong opcode or wrong fields, or raises err_opcode spuriously. A queue count that drifts shows as entries returned out of order, a cmd_valid that stays high after the expected number of pops, or err_overflow set too early or too late during a fill of DEPTH+1 commands.

// File: rtl/gfx_cmd_pkg.sv
// Shared definitions for the SPI graphics command deserializer.
// Assumes the opcode set and payload lengths are fixed by the host protocol.
package gfx_cmd_pkg;

    localparam int PAYLOAD_MAX = 10;
    localparam int RAW_W       = PAYLOAD_MAX * 8;
    localparam int LEN_W       = $clog2(PAYLOAD_MAX + 1);

    localparam logic [7:0] OP_LINE  = 8'h01;
    localparam logic [7:0] OP_CLIP  = 8'h02;
    localparam logic [7:0] OP_CLEAR = 8'h03;
    localparam logic [7:0] OP_SWAP  = 8'h04;

    typedef logic [LEN_W-1:0] len_t;

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] xa;
        logic [15:0] ya;
        logic [15:0] xb;
        logic [15:0] yb;
        logic [7:0]  color;
        logic [7:0]  opt;
    } gfx_cmd_t;

    // True for opcodes the parser accepts.
    function automatic logic op_known(input logic [7:0] op);
        return (op == OP_LINE) || (op == OP_CLIP) || (op == OP_CLEAR) || (op == OP_SWAP);
    endfunction

    // Payload byte count following each opcode.
    function automatic len_t op_len(input logic [7:0] op);
        case (op)
            OP_LINE:  return len_t'(10);
            OP_CLIP:  return len_t'(8);
            OP_CLEAR: return len_t'(1);
            default:  return len_t'(0);
        endcase
    endfunction

    // Maps raw payload bytes (byte i at bits 8*i+7:8*i) to decoded fields.
    function automatic gfx_cmd_t build_cmd(input logic [7:0] op, input logic [RAW_W-1:0] raw);
        gfx_cmd_t c;
        c    = '0;
        c.op = op;
        if (op == OP_LINE || op == OP_CLIP) begin
            c.xa = {raw[0*8 +: 8], raw[1*8 +: 8]};
            c.ya = {raw[2*8 +: 8], raw[3*8 +: 8]};
            c.xb = {raw[4*8 +: 8], raw[5*8 +: 8]};
            c.yb = {raw[6*8 +: 8], raw[7*8 +: 8]};
        end
        if (op == OP_LINE) begin
            c.color = raw[8*8 +: 8];
            c.opt   = raw[9*8 +: 8];
        end
        if (op == OP_CLEAR) begin
            c.color = raw[0 +: 8];
        end
        return c;
    endfunction

endpackage

// File: rtl/spi_byte_rx.sv
// SPI mode-0 byte receiver in the system clock domain.
// Assumes SCK runs well below half the system clock so every SCK level
// lasts at least two system cycles after synchronisation.
module spi_byte_rx #(
    parameter int WORD_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              frame_act,
    output logic              byte_vld,
    output logic [WORD_W-1:0] byte_data
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [SYNC_N:0]     sck_q;
    logic [SYNC_N-1:0]   cs_q;
    logic [SYNC_N-1:0]   mosi_q;
    logic [CNT_W-1:0]    bit_cnt;
    logic [WORD_W-1:0]   shreg;
    logic                sck_rise;
    logic                mosi_s;

    // Synchronise the three SPI lines; sck keeps one extra stage for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[SYNC_N-1:0], sck};
            cs_q   <= {cs_q[SYNC_N-2:0], cs_n};
            mosi_q <= {mosi_q[SYNC_N-2:0], mosi};
        end
    end

    assign sck_rise  = sck_q[SYNC_N-1] & ~sck_q[SYNC_N];
    assign frame_act = ~cs_q[SYNC_N-1];
    assign mosi_s    = mosi_q[SYNC_N-1];

    // Shift in bits on each rising edge and flag each finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (!frame_act) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[WORD_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(WORD_W - 1)) begin
                    bit_cnt   <= '0;
                    byte_vld  <= 1'b1;
                    byte_data <= {shreg[WORD_W-2:0], mosi_s};
                end
            end
        end
    end

    // R2: a word can only complete while the frame was active
    p_byte_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(frame_act));

    // R7: bit counter is cleared whenever the frame is closed
    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |=> (bit_cnt == '0));

endmodule

// File: rtl/cmd_parser.sv
// Opcode/payload state machine: collects payload bytes per opcode and
// emits one decoded command pulse when the last byte arrives.
// Assumes byte_vld pulses are separated by several cycles.
module cmd_parser
    import gfx_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_act,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    output logic       done,
    output gfx_cmd_t   done_cmd,
    output logic       opc_err
);
    typedef enum logic [0:0] {ST_OPC, ST_PAY} state_t;

    state_t           state;
    logic [7:0]       op_q;
    len_t             need;
    len_t             idx;
    logic [RAW_W-1:0] raw;
    logic [RAW_W-1:0] raw_next;

    // Payload image including the byte arriving this cycle.
    always_comb begin
        raw_next = raw;
        raw_next[8*idx +: 8] = byte_data;
    end

    // Track opcode and payload position, emit completed commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_OPC;
            op_q     <= '0;
            need     <= '0;
            idx      <= '0;
            raw      <= '0;
            done     <= 1'b0;
            done_cmd <= '0;
            opc_err  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!frame_act) begin
                state <= ST_OPC;
                idx   <= '0;
            end else if (byte_vld) begin
                case (state)
                    ST_OPC: begin
                        if (!op_known(byte_data)) begin
                            opc_err <= 1'b1;
                        end else if (op_len(byte_data) == '0) begin
                            done     <= 1'b1;
                            done_cmd <= build_cmd(byte_data, '0);
                        end else begin
                            op_q  <= byte_data;
                            need  <= op_len(byte_data);
                            idx   <= '0;
                            raw   <= '0;
                            state <= ST_PAY;
                        end
                    end
                    default: begin
                        raw <= raw_next;
                        idx <= idx + 1'b1;
                        if (idx == need - 1'b1) begin
                            done     <= 1'b1;
                            done_cmd <= build_cmd(op_q, raw_next);
                            idx      <= '0;
                            state    <= ST_OPC;
                        end
                    end
                endcase
            end
        end
    end

    // R3: payload index stays inside the opcode's length
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAY) |-> (idx < need));

    // R8: unknown-opcode flag is sticky
    p_sticky_opc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        opc_err |=> opc_err);

    // R7: a closed frame always returns the parser to opcode wait
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |=> (state == ST_OPC));

endmodule

// File: rtl/cmd_fifo.sv
// Show-ahead queue of decoded commands. A write into a full queue is
// dropped and flagged; assumes one write at most per cycle.
module cmd_fifo
    import gfx_cmd_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  gfx_cmd_t wr_data,
    input  logic     rd,
    output logic     not_empty,
    output gfx_cmd_t rd_data,
    output logic     ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    gfx_cmd_t         mem [DEPTH];
    logic [PTR_W-1:0] wp;
    logic [PTR_W-1:0] rp;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             do_wr;
    logic             do_rd;

    assign full      = (count == CNT_W'(DEPTH));
    assign not_empty = (count != '0);
    assign do_wr     = wr & ~full;
    assign do_rd     = rd & not_empty;
    assign rd_data   = mem[rp];

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    // Pointers, occupancy and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_wr) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr && full) ovf <= 1'b1;
        end
    end

    // R10: occupancy never exceeds the depth
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R10: a dropped write leaves occupancy untouched
    p_drop_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full && !rd) |=> (count == $past(count)));

    // R10: overflow flag is sticky
    p_sticky_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R9: a read from a non-empty queue lowers occupancy when nothing is written
    p_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && not_empty && !wr) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/gfx_cmd_deser.sv
// Top: SPI receiver -> command parser -> decoded command queue.
// Assumes the SPI clock is at most about a sixth of clk.
module gfx_cmd_deser
    import gfx_cmd_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sck,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    input  logic        cmd_ready,
    output logic        cmd_valid,
    output logic [7:0]  cmd_opcode,
    output logic [15:0] cmd_xa,
    output logic [15:0] cmd_ya,
    output logic [15:0] cmd_xb,
    output logic [15:0] cmd_yb,
    output logic [7:0]  cmd_color,
    output logic [7:0]  cmd_option,
    output logic        err_opcode,
    output logic        err_overflow
);
    logic       frame_act;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic       done;
    gfx_cmd_t   done_cmd;
    gfx_cmd_t   head;

    spi_byte_rx #(.WORD_W(8), .SYNC_N(2)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (spi_sck),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .frame_act (frame_act),
        .byte_vld  (byte_vld),
        .byte_data (byte_data)
    );

    cmd_parser i_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_act (frame_act),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .done      (done),
        .done_cmd  (done_cmd),
        .opc_err   (err_opcode)
    );

    cmd_fifo #(.DEPTH(DEPTH)) i_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (done),
        .wr_data   (done_cmd),
        .rd        (cmd_ready),
        .not_empty (cmd_valid),
        .rd_data   (head),
        .ovf       (err_overflow)
    );

    assign cmd_opcode = head.op;
    assign cmd_xa     = head.xa;
    assign cmd_ya     = head.ya;
    assign cmd_xb     = head.xb;
    assign cmd_yb     = head.yb;
    assign cmd_color  = head.color;
    assign cmd_option = head.opt;

    // R9: an entry presented to the engine always carries a known opcode
    p_valid_known_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> op_known(cmd_opcode));

endmodule

// File: tb/test_gfx_cmd_deser.sv
module test_gfx_cmd_deser;
    localparam int HALF  = 4;
    localparam int DEPTH = 8;

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] xa, ya, xb, yb;
        logic [7:0]  col, opt;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, ready = 1'b0;
    logic valid, e_op, e_ovf;
    logic [7:0] op, col, opt;
    logic [15:0] xa, ya, xb, yb;

    int checks = 0, errors = 0;
    exp_t expq[$];

    always #4 clk = ~clk;

    gfx_cmd_deser #(.DEPTH(DEPTH)) i_gfx_cmd_deser (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .cmd_ready(ready), .cmd_valid(valid), .cmd_opcode(op),
        .cmd_xa(xa), .cmd_ya(ya), .cmd_xb(xb), .cmd_yb(yb),
        .cmd_color(col), .cmd_option(opt),
        .err_opcode(e_op), .err_overflow(e_ovf)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int len_of(input logic [7:0] o);
        case (o)
            8'h01: return 10;
            8'h02: return 8;
            8'h03: return 1;
            default: return 0;
        endcase
    endfunction

    // Expected entry from opcode and payload per R3..R6.
    function automatic exp_t model(input logic [7:0] o, input logic [7:0] b [10]);
        exp_t e = '0;
        e.op = o;
        if (o == 8'h01 || o == 8'h02) begin
            e.xa = {b[0], b[1]}; e.ya = {b[2], b[3]};
            e.xb = {b[4], b[5]}; e.yb = {b[6], b[7]};
        end
        if (o == 8'h01) begin e.col = b[8]; e.opt = b[9]; end
        if (o == 8'h03) e.col = b[0];
        return e;
    endfunction

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            mosi = v[i];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic frame_open();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_close();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] o, input logic [7:0] b [10], input bit expect_it);
        send_bits(o, 8);
        for (int i = 0; i < len_of(o); i++) send_bits(b[i], 8);
        if (expect_it) expq.push_back(model(o, b));
    endtask

    task automatic drain(input string tag);
        while (expq.size() > 0) begin
            exp_t e = expq.pop_front();
            @(negedge clk);
            check({tag, " valid"}, 64'(valid), 64'd1);
            check({tag, " op"}, 64'(op), 64'(e.op));
            check({tag, " xa"}, 64'(xa), 64'(e.xa));
            check({tag, " ya"}, 64'(ya), 64'(e.ya));
            check({tag, " xb"}, 64'(xb), 64'(e.xb));
            check({tag, " yb"}, 64'(yb), 64'(e.yb));
            check({tag, " color"}, 64'(col), 64'(e.col));
            check({tag, " option"}, 64'(opt), 64'(e.opt));
            ready = 1'b1;
            @(negedge clk);
            ready = 1'b0;
        end
        @(negedge clk);
        check({tag, " empty after drain"}, 64'(valid), 64'd0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] b [10];
        void'($urandom(32'd7351));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", 64'(valid), 64'd0);
        check("R1 err_opcode", 64'(e_op), 64'd0);
        check("R1 err_overflow", 64'(e_ovf), 64'd0);

        // R3 R2 directed line with asymmetric bytes
        b = '{8'h04, 8'hFF, 8'h02, 8'hCF, 8'h80, 8'h01, 8'h00, 8'h7E, 8'h3C, 8'hA5};
        frame_open(); send_cmd(8'h01, b, 1); frame_close();
        drain("R3 line");

        // R4 R5 R6 R11 three commands in one frame
        frame_open();
        b = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE, 8'hF0, 8'hEE, 8'hDD};
        send_cmd(8'h02, b, 1);
        b = '{8'h5A, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99};
        send_cmd(8'h03, b, 1);
        send_cmd(8'h04, b, 1);
        frame_close();
        drain("R4 R5 R6 R11 mixed");

        // R7 abort mid-command and mid-byte, then a clean clear
        frame_open(); send_bits(8'h01, 8); send_bits(8'h10, 8); send_bits(8'h20, 8); frame_close();
        frame_open(); send_bits(8'hFF, 3); frame_close();
        @(negedge clk);
        check("R7 nothing queued after abort", 64'(valid), 64'd0);
        frame_open();
        b = '{8'hC3, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
        send_cmd(8'h03, b, 1); frame_close();
        check("R7 no opcode error", 64'(e_op), 64'd0);
        drain("R7 after abort");

        // R8 unknown opcode then swap
        frame_open(); send_bits(8'h05, 8); send_cmd(8'h04, b, 1); frame_close();
        check("R8 err_opcode set", 64'(e_op), 64'd1);
        drain("R8 swap after bad opcode");
        frame_open(); send_bits(8'h00, 8); frame_close();
        check("R8 err_opcode sticky", 64'(e_op), 64'd1);
        check("R10 no overflow yet", 64'(e_ovf), 64'd0);

        // R9 R11 random batches
        for (int k = 0; k < 5; k++) begin
            int n = $urandom_range(1, DEPTH);
            frame_open();
            for (int j = 0; j < n; j++) begin
                logic [7:0] o = 8'($urandom_range(1, 4));
                for (int i = 0; i < 10; i++) b[i] = 8'($urandom);
                send_cmd(o, b, 1);
            end
            frame_close();
            drain("R9 R11 random");
        end
        check("R10 still no overflow", 64'(e_ovf), 64'd0);

        // R10 fill DEPTH+1 clears
        frame_open();
        for (int j = 1; j <= DEPTH + 1; j++) begin
            b[0] = 8'(j);
            send_cmd(8'h03, b, j <= DEPTH);
        end
        frame_close();
        check("R10 err_overflow set", 64'(e_ovf), 64'd1);
        drain("R10 kept entries");
        check("R10 err_overflow sticky", 64'(e_ovf), 64'd1);

        finish_run();
    end
endmodule